// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block sits between eight peripheral interrupt lines and one processor interrupt input. A rising edge on a line is stored as a pending request. The controller picks one pending, unmasked line by priority and raises a single interrupt toward the processor. When the processor acknowledges, the chosen line moves from the pending set to the in-service set. The line stays in service until software retires it with an end-of-interrupt command.

Software talks to the block through a byte-wide write port. With the select input low, a write is a command. With the select input high, a write loads the per-line mask. Commands do the following:

- choose the priority order: the default order with line 0 first, or a rotated order;
- retire in-service lines, either the top one or a named one;
- switch a mode that lets lines interrupt regardless of nesting;
- arm a poll.

When a poll is armed, the interrupt output is held quiet and the next status read returns the winning line. That read also counts as an acknowledge. When no poll is armed, the read port shows the in-service or the pending register.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the interrupt output is low and both the in-service and pending registers read 0x00. No line is masked, special mask mode is off, and line 0 has the highest priority and line 7 the lowest.
- R2: A 0-to-1 transition on a line of `irq_in` sets that line's pending bit at the next clock edge. The bit stays set until the line is acknowledged.
- R3: Among eligible pending lines, the one earliest in the current priority order wins. `int_out` is raised and `ack_line` shows the winner's number.
- R4: While `int_out` is high, a one-cycle `int_ack` clears the winner's pending bit and sets its in-service bit. When `int_out` is low, `int_ack` has no effect.
- R5: Outside special mask mode, a pending line raises `int_out` only if it comes strictly earlier in the priority order than every line in service. Lines of equal or later priority stay pending.
- R6: A write with `wr_sel`=1 loads the mask register from `wr_data` (bit n masks line n). A masked line never wins, but its pending bit is still recorded.
- R7: Command 0x20 clears the in-service bit of the line earliest in the current priority order.
- R8: Command 0x60+n (n in 0..7) clears the in-service bit of line n only.
- R9: Command 0xA0 clears the top in-service bit and makes that line the last in the priority order, so the next line becomes first.
- R10: Command 0xC0+n makes line n the last in the priority order. 0xC7 restores the default order.
- R11: Command 0x68 enables special mask mode. In this mode, any unmasked pending line that is not itself in service can interrupt, whatever else is in service. Command 0x48 disables the mode.
- R12: Command 0x0C arms a poll and holds `int_out` low. While the poll is armed, `rd_data` shows 0x80+n for the line that would win, or 0x00 if none would. A cycle with `rd_en` high ends the poll and acknowledges the reported line.
- R13: When no poll is armed, `rd_data` shows the in-service register if `rd_sel`=0, and the pending register if `rd_sel`=1.
- R14: Command bytes other than those listed above change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Interrupt request lines, rising-edge sensitive |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 0: command byte, 1: mask byte |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Status read strobe (completes a poll) |
| rd_sel | input | 1 | 0: in-service register, 1: pending register |
| rd_data | output | 8 | Poll result or selected register |
| int_ack | input | 1 | Processor acknowledge, one cycle |
| int_out | output | 1 | Interrupt request to processor |
| ack_line | output | 3 | Number of the current winning line |

## Verification
Each test sets up a request pattern and then checks the result. Two lines raised together check that the default order decides between them. A higher line arriving while a lower one is in service, and the reverse, separate real nesting from a plain priority encoder. A masked line that stays pending shows that masking gates arbitration but not request capture. A rotating EOI followed by arrivals on both sides of the new boundary shows that the order really moved, and a restore command shows that it moves back. Special mask mode is tried with a later line pending behind an earlier in-service one. Polls are tried both with a request waiting and with nothing pending, to cover both status encodings.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] irq_in,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  input  logic       rd_sel,
  output logic [7:0] rd_data,
  input  logic       int_ack,
  output logic       int_out,
  output logic [2:0] ack_line
);

  logic [7:0] irq_q, irr, isr, imr;
  logic [2:0] low;
  logic       smm, poll_pend;

  function automatic logic [3:0] pick(input logic [7:0] v, input logic [2:0] lo);
    logic [2:0] ln;
    pick = 4'd0;
    for (int k = 7; k >= 0; k--) begin
      ln = lo + 3'(k) + 3'd1;
      if (v[ln]) pick = {1'b1, ln};
    end
  endfunction

  logic [7:0] cand;
  logic       win_v, top_v, allowed, take;
  logic [2:0] win, top, win_rank, top_rank;

  assign cand = irr & ~imr & (smm ? ~isr : 8'hFF);
  assign {win_v, win} = pick(cand, low);
  assign {top_v, top} = pick(isr, low);
  assign win_rank = win - low - 3'd1;
  assign top_rank = top - low - 3'd1;
  assign allowed  = win_v & (smm | ~top_v | (win_rank < top_rank));
  assign int_out  = allowed & ~poll_pend;
  assign ack_line = win_v ? win : 3'd0;
  assign take     = (int_ack & int_out) | (rd_en & poll_pend & allowed);

  logic       cmd, c_ns, c_sp, c_rot, c_low, c_smm_on, c_smm_off, c_poll;
  assign cmd       = wr_en & ~wr_sel;
  assign c_ns      = cmd & (wr_data == 8'h20);
  assign c_sp      = cmd & (wr_data[7:3] == 5'b01100);
  assign c_rot     = cmd & (wr_data == 8'hA0);
  assign c_low     = cmd & (wr_data[7:3] == 5'b11000);
  assign c_smm_on  = cmd & (wr_data == 8'h68);
  assign c_smm_off = cmd & (wr_data == 8'h48);
  assign c_poll    = cmd & (wr_data == 8'h0C);

  logic [7:0] isr_clr, win_bit, edges;
  assign win_bit = take ? (8'd1 << win) : 8'd0;
  assign edges   = irq_in & ~irq_q;
  always_comb begin
    isr_clr = 8'd0;
    if ((c_ns | c_rot) && top_v) isr_clr = 8'd1 << top;
    if (c_sp) isr_clr = 8'd1 << wr_data[2:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= '0; irr <= '0; isr <= '0; imr <= '0;
      low <= 3'd7; smm <= 1'b0; poll_pend <= 1'b0;
    end else begin
      irq_q <= irq_in;
      irr   <= (irr & ~win_bit) | edges;
      isr   <= (isr & ~isr_clr) | win_bit;
      if (wr_en && wr_sel) imr <= wr_data;
      if (c_rot && top_v) low <= top;
      else if (c_low)     low <= wr_data[2:0];
      if (c_smm_on)       smm <= 1'b1;
      else if (c_smm_off) smm <= 1'b0;
      if (c_poll)     poll_pend <= 1'b1;
      else if (rd_en) poll_pend <= 1'b0;
    end
  end

  assign rd_data = poll_pend ? (allowed ? {5'b10000, win} : 8'h00)
                             : (rd_sel ? irr : isr);

  assert_edge_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (edges != 8'd0) |=> ((irr & $past(edges)) == $past(edges)));
  assert_ack_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && int_out) |=> isr[$past(ack_line)]);
  assert_nest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (int_out && !smm) |-> !isr[ack_line]);
  assert_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> !imr[ack_line]);
  assert_specific_eoi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (c_sp && !int_ack && !(rd_en && poll_pend)) |=> !isr[$past(wr_data[2:0])]);
  assert_poll_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    c_poll |=> !int_out);

endmodule

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] irq_in = '0, wr_data = '0, rd_data;
  logic wr_en = 0, wr_sel = 0, rd_en = 0, rd_sel = 0, int_ack = 0, int_out;
  logic [2:0] ack_line;
  int total = 0, fails = 0;
  bit done = 0;

  irq_prio_ctrl dut (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_data(rd_data), .int_ack(int_ack), .int_out(int_out), .ack_line(ack_line));

  always #10 clk = ~clk;

  typedef struct { string req; int sel; logic [7:0] exp; } item_t;
  item_t q[$];
  event go;

  initial forever begin
    item_t it;
    logic [7:0] act;
    @(go);
    while (q.size() > 0) begin
      it = q.pop_front();
      case (it.sel)
        0: act = {7'd0, int_out};
        1: act = {5'd0, ack_line};
        default: act = rd_data;
      endcase
      total++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic look(string r, int sel, logic [7:0] e);
    if (sel == 2) rd_sel = 0;
    if (sel == 3) rd_sel = 1;
    #1;
    q.push_back('{r, sel, e});
    ->go;
    wait (q.size() == 0);
  endtask
  task automatic tick(); @(posedge clk); @(negedge clk); endtask
  task automatic pulse(logic [7:0] m); irq_in = m; tick(); irq_in = '0; endtask
  task automatic cmd(logic [7:0] b); wr_en = 1; wr_sel = 0; wr_data = b; tick(); wr_en = 0; endtask
  task automatic mask(logic [7:0] b); wr_en = 1; wr_sel = 1; wr_data = b; tick(); wr_en = 0; wr_sel = 0; endtask
  task automatic ack(); int_ack = 1; tick(); int_ack = 0; endtask
  task automatic pread(); rd_en = 1; tick(); rd_en = 0; endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    look("R1 int low", 0, 0); look("R1 isr", 2, 8'h00); look("R1 irr", 3, 8'h00);

    pulse(8'h24);
    look("R2 irr latched", 3, 8'h24); look("R3 int", 0, 1); look("R3 winner 2", 1, 2);
    ack();
    look("R4 isr", 2, 8'h04); look("R4 irr", 3, 8'h20); look("R5 lower held", 0, 0);
    pulse(8'h02);
    look("R5 higher nests", 0, 1); look("R5 winner 1", 1, 1);
    ack();
    look("R4 isr nested", 2, 8'h06);
    cmd(8'h20);
    look("R7 nonspecific", 2, 8'h04); look("R5 still held", 0, 0);
    cmd(8'h62);
    look("R8 specific", 2, 8'h00); look("R3 line5 now", 1, 5); look("R3 int", 0, 1);
    ack(); cmd(8'h65);
    look("R8 clear 5", 2, 8'h00); look("R4 irr empty", 3, 8'h00);
    ack();
    look("R4 ack ignored isr", 2, 8'h00);

    mask(8'h08); pulse(8'h08);
    look("R6 masked quiet", 0, 0); look("R6 still recorded", 3, 8'h08);
    mask(8'h00);
    look("R6 unmasked int", 0, 1); look("R6 winner 3", 1, 3);
    ack();
    cmd(8'h00); cmd(8'h33);
    look("R14 ignored", 2, 8'h08);
    pulse(8'h01); ack();
    look("R5 isr two", 2, 8'h09);
    cmd(8'h63);
    look("R8 only that line", 2, 8'h01);
    cmd(8'h20);
    look("R7 clears 0", 2, 8'h00);

    pulse(8'h50); ack();
    look("R4 isr 4", 2, 8'h10);
    cmd(8'hA0);
    look("R9 eoi", 2, 8'h00); look("R9 int", 0, 1); look("R9 winner 6", 1, 6);
    pulse(8'h10);
    look("R9 line4 last", 1, 6);
    pulse(8'h20);
    look("R9 line5 first", 1, 5);
    cmd(8'hC7);
    look("R10 default order", 1, 4);
    ack();
    look("R10 isr", 2, 8'h10); look("R5 blocked", 0, 0);

    cmd(8'h68);
    look("R11 smm int", 0, 1); look("R11 winner 5", 1, 5);
    ack();
    look("R11 isr", 2, 8'h30); look("R11 winner 6", 1, 6);
    cmd(8'h48);
    look("R11 off blocks", 0, 0);
    cmd(8'h20);
    look("R7 clear 4", 2, 8'h20); look("R5 blocked 6", 0, 0);
    cmd(8'h20); ack(); cmd(8'h66);
    look("R8 clean", 2, 8'h00); look("R13 irr empty", 3, 8'h00);

    pulse(8'h08);
    look("R3 int 3", 0, 1);
    cmd(8'h0C);
    look("R12 suppressed", 0, 0); look("R12 poll byte", 4, 8'h83);
    pread();
    look("R12 acked isr", 2, 8'h08); look("R12 irr", 3, 8'h00); look("R12 int", 0, 0);
    cmd(8'h63);
    cmd(8'h0C);
    look("R12 none", 4, 8'h00);
    pread();
    look("R13 isr after poll", 2, 8'h00);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule